// File: doc/BRIEF.md
# Six-State Toggle Sequence Counter

This block is a synchronous three-bit counter that walks a fixed ring of six codes: 000, 001, 011, 111, 110, 100, and then back to 000. Each state bit is a toggle-type storage element. On every enabled clock edge, the bit either keeps its value or inverts it. The toggle decisions come from small excitation equations over the present state, not from a next-state table. Adjacent codes in the ring differ in exactly one bit, so a single bit changes on each step. This makes the block useful as a glitch-free phase sequencer, or as a divide-by-six source with one-bit transitions.

The two codes outside the ring, 010 and 101, cannot be reached in normal operation. They can still appear after an upset. The minimal excitation equations alone would bounce the counter between these two codes forever. The block therefore detects both codes and steers them to 000 on the next enabled edge. A one-cycle wrap pulse marks each completed lap.

Top module: `seq6_counter`

## Requirements
- R1: A synchronous, active-high reset sets the state to 000 and the wrap output to 0 at the next rising edge, even when the enable is high at the same time.
- R2: With the enable high on every edge, the state output (bit 2 is the most significant) follows 000, 001, 011, 111, 110, 100 and repeats.
- R3: Each state bit inverts or holds according to its toggle term. The top bit toggles when bit 2 differs from bit 1. The middle bit toggles when bit 1 differs from bit 0. The low bit toggles when bit 2 equals bit 0.
- R4: On an edge where the enable is low, the state is unchanged. This holds for the ring codes and for the codes 010 and 101.
- R5: When the state is 010 or 101, the next enabled edge sets it to 000, and the wrap output stays 0.
- R6: The wrap output is 1 for exactly the one cycle that follows an enabled edge that moves the state from 100 to 000, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Count enable; low gates every toggle term to 0 |
| state_o | output | 3 | Present counter code |
| wrap_o | output | 1 | One-cycle pulse after each 100 to 000 step |

## Verification
The bench drives the counter into 010 and 101 and checks that one enabled edge lands it on 000. A design that kept only the minimal equations would instead hop to the other unused code and stay trapped in that pair. It also holds an unused code with the enable low, which catches recovery logic that ignores the enable. It applies the reset together with the enable mid-lap, which exposes a reset that loses priority. It also checks the cycle after a lap ends, which catches a wrap pulse that is stretched or that fires on the recovery step.

// File: rtl/seq6_pkg.sv
package seq6_pkg;

    localparam int unsigned CNT_W = 3;

    typedef logic [CNT_W-1:0] code_t;

    localparam code_t CODE_ZERO  = code_t'(0);
    localparam code_t CODE_LAST  = 3'b100;
    localparam code_t CODE_SPARE_A = 3'b010;
    localparam code_t CODE_SPARE_B = 3'b101;

    typedef struct packed {
        code_t tog;
        logic  spare;
    } excite_t;

    function automatic logic is_spare(code_t c);
        return (c == CODE_SPARE_A) || (c == CODE_SPARE_B);
    endfunction

    // minimal toggle terms, unused codes taken as don't-care
    function automatic code_t tog_min(code_t q);
        code_t t;
        t[2] = q[2] ^ q[1];
        t[1] = q[1] ^ q[0];
        t[0] = ~(q[2] ^ q[0]);
        return t;
    endfunction

    // ring successor, used only by the checks
    function automatic code_t ring_next(code_t q);
        case (q)
            3'b000:  return 3'b001;
            3'b001:  return 3'b011;
            3'b011:  return 3'b111;
            3'b111:  return 3'b110;
            3'b110:  return 3'b100;
            3'b100:  return 3'b000;
            default: return CODE_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/seq6_excite.sv
module seq6_excite
    import seq6_pkg::*;
(
    input  code_t   q_i,
    input  logic    en_i,
    output excite_t ex_o
);
    code_t raw;

    always_comb begin
        // an unused code toggles exactly its ones, landing on zero
        if (is_spare(q_i)) raw = q_i;
        else               raw = tog_min(q_i);
    end

    for (genvar b = 0; b < CNT_W; b++) begin : g_gate
        assign ex_o.tog[b] = en_i & raw[b];
    end

    assign ex_o.spare = is_spare(q_i);

endmodule

// File: rtl/seq6_tbank.sv
module seq6_tbank
    import seq6_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  code_t tog_i,
    output code_t q_o
);
    code_t state_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= CODE_ZERO;
        else       state_q <= state_q ^ tog_i;
    end

    assign q_o = state_q;

endmodule

// File: rtl/seq6_wrap.sv
module seq6_wrap
    import seq6_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  en_i,
    input  code_t q_i,
    output logic  wrap_o
);
    logic wrap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) wrap_q <= 1'b0;
        else       wrap_q <= en_i && (q_i == CODE_LAST);
    end

    assign wrap_o = wrap_q;

    // R6: a pulse never lasts two cycles
    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_q |=> !wrap_q);

endmodule

// File: rtl/seq6_counter.sv
module seq6_counter
    import seq6_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] state_o,
    output logic             wrap_o
);
    code_t   q;
    excite_t ex;

    seq6_excite u_excite (
        .q_i  (q),
        .en_i (en_i),
        .ex_o (ex)
    );

    seq6_tbank u_bank (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tog_i (ex.tog),
        .q_o   (q)
    );

    seq6_wrap u_wrap (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .q_i    (q),
        .wrap_o (wrap_o)
    );

    assign state_o = q;

    // R2, R3: a ring code steps to its successor
    a_r2_ring_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !is_spare(q)) |=> (q == ring_next($past(q))));

    // R4: disabled edges keep the state
    a_r4_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(q));

    // R5: unused codes escape to zero in one enabled edge
    a_r5_recover: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && ex.spare) |=> (q == CODE_ZERO));

    // R6: a pulse always sits on the zero code
    a_r6_wrap_at_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |-> (q == CODE_ZERO));

endmodule

// File: tb/seq6_counter_tb_top.sv
module seq6_counter_tb_top;

    typedef struct packed {
        logic       rst;
        logic       en;
        logic [2:0] st;
        logic       w;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    // each row: inputs for one edge, outputs expected after it
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 3'b001, 1'b0, 4'd2},  // R2
        '{1'b0, 1'b1, 3'b011, 1'b0, 4'd3},  // R3
        '{1'b0, 1'b1, 3'b111, 1'b0, 4'd2},
        '{1'b0, 1'b1, 3'b110, 1'b0, 4'd3},
        '{1'b0, 1'b0, 3'b110, 1'b0, 4'd4},  // R4
        '{1'b0, 1'b1, 3'b100, 1'b0, 4'd2},
        '{1'b0, 1'b1, 3'b000, 1'b1, 4'd6},  // R6
        '{1'b0, 1'b1, 3'b001, 1'b0, 4'd6},
        '{1'b0, 1'b1, 3'b011, 1'b0, 4'd2},
        '{1'b1, 1'b1, 3'b000, 1'b0, 4'd1},  // R1
        '{1'b0, 1'b1, 3'b001, 1'b0, 4'd2},
        '{1'b0, 1'b1, 3'b011, 1'b0, 4'd2},
        '{1'b0, 1'b1, 3'b111, 1'b0, 4'd3},
        '{1'b0, 1'b1, 3'b110, 1'b0, 4'd2},
        '{1'b0, 1'b1, 3'b100, 1'b0, 4'd3},
        '{1'b0, 1'b1, 3'b000, 1'b1, 4'd6},
        '{1'b0, 1'b0, 3'b000, 1'b0, 4'd6},
        '{1'b0, 1'b0, 3'b000, 1'b0, 4'd4}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [2:0] st;
    logic       wrap;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    seq6_counter dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .en_i    (en),
        .state_o (st),
        .wrap_o  (wrap)
    );

    task automatic check(string req, logic [2:0] exp_st, logic exp_w);
        checks++;
        if (st !== exp_st || wrap !== exp_w) begin
            errors++;
            $display("FAIL %s: state=%b wrap=%b expected state=%b wrap=%b",
                     req, st, wrap, exp_st, exp_w);
        end
    endtask

    // reset, then put an arbitrary code into the state register
    task automatic plant(logic [2:0] code, logic en_v);
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        en  = en_v;
        force dut_i.u_bank.state_q = code;
        #1;
        release dut_i.u_bank.state_q;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", 3'b000, 1'b0);  // R1 reset state

        for (int i = 0; i < NV; i++) begin
            rst = VECS[i].rst;
            en  = VECS[i].en;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d", VECS[i].req), VECS[i].st, VECS[i].w);
        end

        // R5: 010 escapes to zero without a wrap pulse
        plant(3'b010, 1'b1);
        check("R5", 3'b010, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R5", 3'b000, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R5", 3'b001, 1'b0);

        // R5: 101 escapes to zero
        plant(3'b101, 1'b1);
        @(posedge clk); @(negedge clk);
        check("R5", 3'b000, 1'b0);

        // R4: an unused code holds while disabled
        plant(3'b101, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R4", 3'b101, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R4", 3'b010 ^ 3'b111, 1'b0);

        // R1: reset with enable high clears an unused code
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", 3'b000, 1'b0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2", 3'b001, 1'b0);

        finish_run();
    end

endmodule